// File: doc/BRIEF.md
# Multi-Format Serial PCM Receiver

This block takes stereo PCM audio from a three-wire serial port (a frame clock, a bit clock and one data line) and turns it into parallel 24-bit words. It is the slave on that port: it runs entirely on the incoming bit clock, samples both the frame clock and the data on the bit clock's rising edge, and assumes 32 bit clocks for each channel, 64 for each stereo frame. When a stereo frame is complete it presents the left and right words together with a one-cycle strobe.

A 2-bit format selector chooses how the data sits in each half-frame. Four framings are supported: left-justified and I2S, both carrying up to 24 bits from the most significant end, and right-justified at exactly 16 or exactly 24 bits, where the word ends on the last bit before the next frame-clock edge. Sixteen-bit words are delivered in the upper bits of the output with zero low bits, so they keep their sign and scale. The selector is only taken into use at a stereo frame boundary, so a word is never decoded half in one framing and half in another.

Top module: `pcm_serial_rx`

## Requirements
- R1: Synchronous active-high reset clears both words to zero and the strobe to 0, and sets the active framing to left-justified; that framing stays in use, whatever `fmt_sel` holds, until the first complete stereo frame has ended.
- R2: Left-justified (selector 2'b00): the word's MSB is the bit sampled on the first rising bit-clock edge that sees the new frame-clock level, the next 23 bits follow MSB first, and the half with frame clock high is the left channel.
- R3: I2S (selector 2'b01): the MSB is sampled one bit clock later than in R2 (second edge of the half), 24 bits follow, and the half with frame clock low is the left channel.
- R4: Right-justified 24-bit (selector 2'b11): the word is the last 24 bits of the 32-bit half, its LSB the final bit before the next frame-clock change; frame clock high is left.
- R5: Right-justified 16-bit (selector 2'b10): the last 16 bits of the half land in output bits 23:8 and output bits 7:0 are zero; frame clock high is left.
- R6: Data bits sampled outside the active framing's window have no effect on the words.
- R7: `pair_stb` is a single-cycle pulse, registered at the rising edge that first sees the frame-clock change ending the right half; both words update only at that pulse and hold their values until the next one.
- R8: A new `fmt_sel` value is adopted only at the frame-clock change that ends a right half; a frame already under way finishes in the framing it started with.
- R9: A stereo pair is emitted only when a fully observed left half is followed by a fully observed right half; a right half with no preceding left half (for example the first half after a switch of polarity) yields no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; every register and every sample uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 2 | Requested framing: 00 left-justified, 01 I2S, 10 right-justified 16-bit, 11 right-justified 24-bit |
| frame_clk | input | 1 | Frame (channel-select) clock, one level per channel |
| ser_data | input | 1 | Serial data, MSB first |
| left_pcm | output | 24 | Left word of the last completed stereo frame |
| right_pcm | output | 24 | Right word of the last completed stereo frame |
| pair_stb | output | 1 | One-cycle pulse when a new stereo pair is presented |

## Verification
Frames are sent in every framing with words chosen to expose ordering and alignment faults: alternating nibble patterns and mirrored pairs reveal a one-bit shift or reversed bit order, while full-scale negative, all-ones and single-LSB values reveal a lost MSB or LSB and wrong sign placement for 16-bit data. Every slot outside the data window is driven high, so any capture outside the window shows up as stray ones. The selector is changed once in the middle of a frame and once exactly at a boundary, which separates immediate from boundary-timed adoption, and an orphan right half after the switch to I2S polarity shows whether unpaired halves are suppressed.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ   = 2'b00,
    FMT_I2S  = 2'b01,
    FMT_RJ16 = 2'b10,
    FMT_RJ24 = 2'b11
  } rx_fmt_e;

  // True when the channel carried while the frame clock is low is the right one.
  function automatic logic low_half_is_right(rx_fmt_e f);
    return f != FMT_I2S;
  endfunction

endpackage

// File: rtl/rx_edge_track.sv
// Follows the frame clock: detects level changes and counts bit slots in the
// current half-frame. slot_idx is the slot index of the bit sampled this edge.
module rx_edge_track #(
  parameter int HALF_BITS = 32,
  localparam int IDX_W = $clog2(HALF_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_clk,
  output logic             lvl_prev,
  output logic             edge_seen,
  output logic             synced,
  output logic [IDX_W-1:0] slot_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(HALF_BITS - 1);

  logic             primed_q;
  logic             lvl_q;
  logic             synced_q;
  logic [IDX_W-1:0] idx_q;

  assign edge_seen = primed_q && (frame_clk != lvl_q);
  assign lvl_prev  = lvl_q;
  assign synced    = synced_q;

  always_comb begin
    if (edge_seen)
      slot_idx = '0;
    else if (idx_q == IDX_MAX)
      slot_idx = idx_q;
    else
      slot_idx = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      lvl_q    <= 1'b0;
      synced_q <= 1'b0;
      idx_q    <= IDX_MAX;
    end else begin
      primed_q <= 1'b1;
      lvl_q    <= frame_clk;
      idx_q    <= slot_idx;
      if (edge_seen)
        synced_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_format_reg.sv
// Holds the framing in use; a request is adopted only on a frame boundary.
// fmt_now bypasses the register so the first slot of a new frame is decoded
// with the framing that frame will use.
module rx_format_reg
  import pcm_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    boundary,
  input  rx_fmt_e fmt_req,
  output rx_fmt_e fmt_active,
  output rx_fmt_e fmt_now
);
  always_ff @(posedge clk) begin
    if (rst)
      fmt_active <= FMT_LJ;
    else if (boundary)
      fmt_active <= fmt_req;
  end

  assign fmt_now = boundary ? fmt_req : fmt_active;
endmodule

// File: rtl/rx_bit_capture.sv
// Writes each in-window bit straight into its final position of the word.
// The accumulator restarts from zero on every frame-clock change.
module rx_bit_capture
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int HALF_BITS = 32,
  parameter int SHORT_W   = 16,
  localparam int IDX_W = $clog2(HALF_BITS),
  localparam int POS_W = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                edge_seen,
  input  logic [IDX_W-1:0]    slot_idx,
  input  rx_fmt_e             fmt_now,
  input  logic                ser_data,
  output logic [SAMPLE_W-1:0] word_q
);
  logic [SAMPLE_W-1:0] acc_q;
  logic [SAMPLE_W-1:0] acc_nxt;
  logic [POS_W-1:0]    pos;
  logic                hit;
  int                  win_start;
  int                  win_len;
  int                  rel;

  always_comb begin
    win_start = 0;
    win_len   = SAMPLE_W;
    case (fmt_now)
      FMT_LJ:   begin win_start = 0;                    win_len = SAMPLE_W; end
      FMT_I2S:  begin win_start = 1;                    win_len = SAMPLE_W; end
      FMT_RJ16: begin win_start = HALF_BITS - SHORT_W;  win_len = SHORT_W;  end
      FMT_RJ24: begin win_start = HALF_BITS - SAMPLE_W; win_len = SAMPLE_W; end
      default:  begin win_start = 0;                    win_len = SAMPLE_W; end
    endcase
    rel = int'(slot_idx) - win_start;
    hit = (rel >= 0) && (rel < win_len);
    pos = hit ? POS_W'(SAMPLE_W - 1 - rel) : '0;
    acc_nxt = edge_seen ? '0 : acc_q;
    if (hit)
      acc_nxt[pos] = ser_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else
      acc_q <= acc_nxt;
  end

  assign word_q = acc_q;
endmodule

// File: rtl/rx_pair_out.sv
// Pairs a completed left word with the following right word and registers
// both outputs plus the strobe.
module rx_pair_out #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                half_done,
  input  logic                half_is_right,
  input  logic [SAMPLE_W-1:0] word,
  output logic [SAMPLE_W-1:0] left_pcm,
  output logic [SAMPLE_W-1:0] right_pcm,
  output logic                pair_stb
);
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_pcm  <= '0;
      right_pcm <= '0;
      pair_stb  <= 1'b0;
    end else begin
      pair_stb <= 1'b0;
      if (half_done) begin
        if (!half_is_right) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else begin
          have_left <= 1'b0;
          if (have_left) begin
            left_pcm  <= left_hold;
            right_pcm <= word;
            pair_stb  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int HALF_BITS = 32,
  parameter int SHORT_W   = 16
) (
  input  logic                bit_clk,
  input  logic                rst,
  input  logic [1:0]          fmt_sel,
  input  logic                frame_clk,
  input  logic                ser_data,
  output logic [SAMPLE_W-1:0] left_pcm,
  output logic [SAMPLE_W-1:0] right_pcm,
  output logic                pair_stb
);
  localparam int IDX_W = $clog2(HALF_BITS);

  logic                lvl_prev;
  logic                edge_seen;
  logic                synced;
  logic [IDX_W-1:0]    slot_idx;
  rx_fmt_e             fmt_active;
  rx_fmt_e             fmt_now;
  logic [SAMPLE_W-1:0] word_q;
  logic                half_done;
  logic                half_is_right;
  logic                boundary;

  // A half is complete when a level change ends it and its start was seen.
  assign half_done     = edge_seen && synced;
  assign half_is_right = low_half_is_right(fmt_active) ? !lvl_prev : lvl_prev;
  assign boundary      = half_done && half_is_right;

  rx_edge_track #(.HALF_BITS(HALF_BITS)) u_edge (
    .clk       (bit_clk),
    .rst       (rst),
    .frame_clk (frame_clk),
    .lvl_prev  (lvl_prev),
    .edge_seen (edge_seen),
    .synced    (synced),
    .slot_idx  (slot_idx)
  );

  rx_format_reg u_fmt (
    .clk        (bit_clk),
    .rst        (rst),
    .boundary   (boundary),
    .fmt_req    (rx_fmt_e'(fmt_sel)),
    .fmt_active (fmt_active),
    .fmt_now    (fmt_now)
  );

  rx_bit_capture #(
    .SAMPLE_W  (SAMPLE_W),
    .HALF_BITS (HALF_BITS),
    .SHORT_W   (SHORT_W)
  ) u_cap (
    .clk       (bit_clk),
    .rst       (rst),
    .edge_seen (edge_seen),
    .slot_idx  (slot_idx),
    .fmt_now   (fmt_now),
    .ser_data  (ser_data),
    .word_q    (word_q)
  );

  rx_pair_out #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk           (bit_clk),
    .rst           (rst),
    .half_done     (half_done),
    .half_is_right (half_is_right),
    .word          (word_q),
    .left_pcm      (left_pcm),
    .right_pcm     (right_pcm),
    .pair_stb      (pair_stb)
  );
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_clk,
  input logic                pair_stb,
  input logic [SAMPLE_W-1:0] left_pcm,
  input logic [SAMPLE_W-1:0] right_pcm,
  input logic [1:0]          fmt_active,
  input logic                boundary
);
  localparam int PAD_W = SAMPLE_W - SHORT_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pair_stb && left_pcm == '0 && right_pcm == '0 && fmt_active == 2'b00));

  // R7
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    pair_stb |=> !pair_stb);

  // R7
  stb_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    pair_stb |-> ($past(frame_clk) != $past(frame_clk, 2)));

  // R7
  words_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pair_stb |-> ($stable(left_pcm) && $stable(right_pcm)));

  // R5
  short_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_stb && $past(fmt_active) == 2'b10) |->
      (left_pcm[PAD_W-1:0] == '0 && right_pcm[PAD_W-1:0] == '0));

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(fmt_active));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(
  .SAMPLE_W (SAMPLE_W),
  .SHORT_W  (SHORT_W)
) u_chk (
  .clk        (bit_clk),
  .rst        (rst),
  .frame_clk  (frame_clk),
  .pair_stb   (pair_stb),
  .left_pcm   (left_pcm),
  .right_pcm  (right_pcm),
  .fmt_active (fmt_active),
  .boundary   (boundary)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  logic bit_clk = 1'b0;
  always #5 bit_clk = ~bit_clk;

  logic        rst       = 1'b1;
  logic [1:0]  fmt_sel   = 2'b00;
  logic        frame_clk = 1'b0;
  logic        ser_data  = 1'b0;
  logic [23:0] left_pcm;
  logic [23:0] right_pcm;
  logic        pair_stb;

  pcm_serial_rx u_dut (
    .bit_clk   (bit_clk),
    .rst       (rst),
    .fmt_sel   (fmt_sel),
    .frame_clk (frame_clk),
    .ser_data  (ser_data),
    .left_pcm  (left_pcm),
    .right_pcm (right_pcm),
    .pair_stb  (pair_stb)
  );

  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;
  bit          prev_stb = 1'b0;
  logic [23:0] q_l[$];
  logic [23:0] q_r[$];
  string       q_t[$];
  logic [23:0] last_l = '0;
  logic [23:0] last_r = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Serial value of slot i of a half carrying word d; unused slots are 1.
  function automatic logic slot_bit(input logic [1:0] f, input logic [23:0] d, input int i);
    case (f)
      2'b00:   return (i < 24) ? d[23-i] : 1'b1;
      2'b01:   return (i >= 1 && i <= 24) ? d[24-i] : 1'b1;
      2'b10:   return (i >= 16) ? d[23-(i-16)] : 1'b1;
      default: return (i >= 8) ? d[31-i] : 1'b1;
    endcase
  endfunction

  task automatic drive(input logic lr, input logic d);
    @(negedge bit_clk);
    frame_clk = lr;
    ser_data  = d;
  endtask

  task automatic send_half(input logic lr, input logic [1:0] f, input logic [23:0] d);
    for (int i = 0; i < 32; i++) drive(lr, slot_bit(f, d, i));
  endtask

  task automatic expect_pair(input logic [1:0] f, input logic [23:0] l,
                             input logic [23:0] r, input string tag);
    logic [23:0] el, er;
    el = (f == 2'b10) ? {l[23:8], 8'h00} : l;
    er = (f == 2'b10) ? {r[23:8], 8'h00} : r;
    q_l.push_back(el);
    q_r.push_back(er);
    q_t.push_back(tag);
    last_l = el;
    last_r = er;
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [23:0] l,
                            input logic [23:0] r, input string tag);
    logic first;
    first = (f == 2'b01) ? 1'b0 : 1'b1;
    expect_pair(f, l, r, tag);
    send_half(first, f, l);
    send_half(!first, f, r);
  endtask

  task automatic do_reset(input logic [1:0] f);
    @(negedge bit_clk);
    rst = 1'b1;
    fmt_sel = f;
    frame_clk = 1'b0;
    ser_data = 1'b0;
    repeat (4) @(negedge bit_clk);
    rst = 1'b0;
    @(negedge bit_clk);
    // R1: cleared outputs right after reset
    check(pair_stb == 1'b0, "R1", "strobe after reset", {23'h0, pair_stb}, 24'h0);
    check(left_pcm == 24'h0, "R1", "left after reset", left_pcm, 24'h0);
    check(right_pcm == 24'h0, "R1", "right after reset", right_pcm, 24'h0);
  endtask

  task automatic finish_segment(input logic lr, input logic [1:0] f);
    send_half(lr, f, 24'h000000);
    repeat (2) @(negedge bit_clk);
    // R7: words held after the last strobe, every expected pair seen
    check(left_pcm == last_l, "R7", "left held", left_pcm, last_l);
    check(right_pcm == last_r, "R7", "right held", right_pcm, last_r);
    check(q_l.size() == 0, "R7", "pending pairs", 24'(q_l.size()), 24'h0);
  endtask

  // Monitor: pops the scoreboard on every strobe.
  always @(negedge bit_clk) begin
    if (!rst && pair_stb) begin
      check(!prev_stb, "R7", "strobe width", 24'h2, 24'h1);
      if (q_l.size() == 0) begin
        check(1'b0, "R9", "unexpected strobe", left_pcm, 24'h0);
      end else begin
        logic [23:0] el, er;
        string tg;
        el = q_l.pop_front();
        er = q_r.pop_front();
        tg = q_t.pop_front();
        check(left_pcm == el, tg, "left word", left_pcm, el);
        check(right_pcm == er, tg, "right word", right_pcm, er);
      end
    end
    prev_stb = rst ? 1'b0 : pair_stb;
  end

  initial begin
    // Segment A: default framing, right-justified modes, boundary switching.
    do_reset(2'b11);
    repeat (5) drive(1'b0, 1'b1);                 // partial half before sync
    // R1: first frame decoded left-justified although 11 is requested
    send_frame(2'b00, 24'hA5C31E, 24'h5A3CE1, "R1");
    // R4: right-justified 24-bit
    send_frame(2'b11, 24'h800001, 24'h7FFFFE, "R4");
    send_frame(2'b11, 24'h123456, 24'hFEDCBA, "R4");
    // R8: selector changes mid frame, this frame stays 24-bit
    expect_pair(2'b11, 24'h0F0F0F, 24'hF0F0F0, "R8");
    send_half(1'b1, 2'b11, 24'h0F0F0F);
    fmt_sel = 2'b10;
    send_half(1'b0, 2'b11, 24'hF0F0F0);
    // R5: right-justified 16-bit, low byte of the word zero
    send_frame(2'b10, 24'hBEEF77, 24'h8001AA, "R5");
    send_frame(2'b10, 24'h7FFF00, 24'h0001FF, "R5");
    // R8: switch exactly at the boundary to left-justified
    fmt_sel = 2'b00;
    send_frame(2'b00, 24'hFFFFFF, 24'h000001, "R8");
    // R2 and R6: left-justified with padding ones after the word
    send_frame(2'b00, 24'hC0FFEE, 24'h135799, "R2");
    send_frame(2'b00, 24'h000000, 24'h800000, "R6");
    finish_segment(1'b1, 2'b00);

    // Segment B: I2S reached through a polarity switch.
    do_reset(2'b01);
    repeat (5) drive(1'b0, 1'b1);
    send_frame(2'b00, 24'h3C3C3C, 24'hC3C3C3, "R1");
    // R9: orphan right half under I2S polarity yields no strobe
    send_half(1'b1, 2'b01, 24'h777777);
    // R3: I2S frames, slot 0 padded with a one (R6)
    send_frame(2'b01, 24'h876543, 24'h00FF00, "R3");
    send_frame(2'b01, 24'h800000, 24'h7FFFFF, "R3");
    send_frame(2'b01, 24'h000000, 24'h000000, "R6");
    finish_segment(1'b0, 2'b01);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge bit_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule